// File: doc/BRIEF.md
# Serial Flash Slave Front End with Clock-Qualified Pause

This block is the slave-side pin front end of a serial flash device. It oversamples the chip-select, serial clock, serial data-in, pause and write-protect pins with a fast system clock. It shifts command and data bytes in MSB first and shifts the status register out on the serial output. Downstream command logic gets each received byte as a one-cycle strobe and a reset pulse whenever chip-select is released.

A transfer can be frozen part way through a byte by pulling the active-low pause pin. The freeze is tied to the low phase of the serial clock. A pause edge that arrives while the clock is high waits for the next clock low before it takes effect. While the block is paused, the output driver is released and clock and data activity is ignored. When the pause ends, the transfer carries on from the same bit.

The only command decoded here is the status-register write: opcode 0x01 followed by one data byte. A lock bit in the status register, together with the write-protect pin, decides whether that write is accepted or refused.

Top module: `spi_hold_frontend`

## Requirements
- R1: The pause state (`hold_active`=1) is entered only while synchronized chip-select is low. With `cs_n_pin` high, a low `hold_n_pin` leaves `hold_active` at 0.
- R2: If `hold_n_pin` falls while `sck_pin` is low, `hold_active` becomes 1 within 3 system clock cycles.
- R3: If `hold_n_pin` falls while `sck_pin` is high, `hold_active` stays 0 until `sck_pin` goes low, and becomes 1 within 3 cycles after that.
- R4: The pause ends when `hold_n_pin` is high while `sck_pin` is low. If `hold_n_pin` rises while `sck_pin` is high, `hold_active` stays 1 until `sck_pin` goes low.
- R5: While `hold_active` is 1, `so_oe` is 0. Edges on `sck_pin` and levels on `si_pin` do not change the received data or the bit position.
- R6: After a pause, the transfer resumes at the bit where it stopped, so the byte received equals the byte sent with the pause-time activity removed.
- R7: A high level on `cs_n_pin` clears the pause state, the bit counter and the command phase. The rising edge of synchronized chip-select produces a one-cycle `cmd_reset` pulse. The next transfer starts again at bit 7.
- R8: The second byte of a transfer whose first byte is 0x01 is written to `status_reg` (pulse on `wrsr_done`) when status bit 7 is 0 or `wp_n_pin` is 1.
- R9: When status bit 7 is 1 and `wp_n_pin` is 0, that write is refused. `status_reg` is unchanged and `wrsr_rejected` pulses for one cycle.
- R10: Outside a pause, `si_pin` is sampled on rising `sck_pin` edges, MSB first. After eight samples, `rx_byte` holds the byte and `rx_valid` pulses for one cycle.
- R11: With chip-select low and no pause, `so_oe` is 1. `so` presents the status register MSB first. Bit 7 is valid before the first rising edge of a byte, and each following bit is launched on a falling edge.
- R12: A transfer whose first byte is not 0x01 does not change `status_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_pin | input | 1 | Chip select, active low |
| sck_pin | input | 1 | Serial clock |
| si_pin | input | 1 | Serial data in |
| hold_n_pin | input | 1 | Pause request, active low |
| wp_n_pin | input | 1 | Write protect, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output driver enable for `so` |
| hold_active | output | 1 | Effective pause state |
| cmd_reset | output | 1 | One-cycle pulse when chip-select is released |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| status_reg | output | 8 | Status register; bit 7 is the lock bit |
| wrsr_done | output | 1 | Status write accepted |
| wrsr_rejected | output | 1 | Status write refused |

## Verification
The assertions assume that each pin stays stable for several system clocks, so that every serial clock level reaches the synchronized domain as a separate sample. They also assume that the pause pin changes only while chip-select is low or idle. The stimulus holds each serial clock phase and each pause-pin level for six system clocks, and drives pins only on falling system-clock edges. Random transfers vary the opcode, the data, the write-protect level, the bit at which a pause is inserted, and whether pause entry and exit land in the clock's high or low phase.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int          DATA_W    = 8;
  localparam logic [7:0]  WRSR_OP   = 8'h01;
  localparam int          LOCK_BIT  = 7;

  typedef enum logic [1:0] {
    PH_OPCODE = 2'd0,
    PH_DATA   = 2'd1,
    PH_IGNORE = 2'd2
  } cmd_phase_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int          WIDTH   = 5,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= RST_VAL;
        else     stage[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= RST_VAL;
        else     stage[s] <= stage[s-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/hold_qual.sv
module hold_qual (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_s,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic hold_active,
  output logic so_oe
);
  logic hold_next;

  // Entry and exit both wait for a low serial clock sample.
  always_comb begin
    hold_next = hold_active;
    if (cs_n_s)
      hold_next = 1'b0;
    else if (!sck_s)
      hold_next = !hold_n_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_active <= 1'b0;
      so_oe       <= 1'b0;
    end else begin
      hold_active <= hold_next;
      so_oe       <= !cs_n_s && !hold_next;
    end
  end
endmodule

// File: rtl/bit_shifter.sv
module bit_shifter #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n_s,
  input  logic          sck_s,
  input  logic          si_s,
  input  logic          hold_active,
  input  logic [DW-1:0] tx_load,
  output logic          so,
  output logic [DW-1:0] rx_byte,
  output logic          rx_valid,
  output logic [CW-1:0] bit_cnt,
  output logic          cmd_reset
);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          sck_prev, cs_prev;
  logic [DW-1:0] rx_sh, tx_sh;
  logic          rise, fall;

  assign rise = sck_s && !sck_prev && !hold_active;
  assign fall = !sck_s && sck_prev && !hold_active;
  assign so   = tx_sh[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev  <= 1'b0;
      cs_prev   <= 1'b1;
      cmd_reset <= 1'b0;
    end else begin
      sck_prev  <= sck_s;
      cs_prev   <= cs_n_s;
      cmd_reset <= cs_n_s && !cs_prev;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      tx_sh    <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
        tx_sh   <= tx_load;
      end else begin
        if (rise) begin
          rx_sh   <= {rx_sh[DW-2:0], si_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST) begin
            rx_byte  <= {rx_sh[DW-2:0], si_s};
            rx_valid <= 1'b1;
          end
        end
        if (fall) begin
          if (bit_cnt == '0) tx_sh <= tx_load;
          else               tx_sh <= {tx_sh[DW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/wrsr_gate.sv
module wrsr_gate
  import spi_hold_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n_s,
  input  logic          wp_n_s,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_valid,
  output logic [DW-1:0] status_reg,
  output logic          wrsr_done,
  output logic          wrsr_rejected
);
  cmd_phase_t phase;
  logic       locked;

  assign locked = status_reg[LOCK_BIT] && !wp_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase         <= PH_OPCODE;
      status_reg    <= '0;
      wrsr_done     <= 1'b0;
      wrsr_rejected <= 1'b0;
    end else begin
      wrsr_done     <= 1'b0;
      wrsr_rejected <= 1'b0;
      if (cs_n_s) begin
        phase <= PH_OPCODE;
      end else if (rx_valid) begin
        case (phase)
          PH_OPCODE: phase <= (rx_byte == DW'(WRSR_OP)) ? PH_DATA : PH_IGNORE;
          PH_DATA: begin
            phase <= PH_IGNORE;
            if (locked) begin
              wrsr_rejected <= 1'b1;
            end else begin
              status_reg <= rx_byte;
              wrsr_done  <= 1'b1;
            end
          end
          default: phase <= PH_IGNORE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DW          = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n_pin,
  input  logic          sck_pin,
  input  logic          si_pin,
  input  logic          hold_n_pin,
  input  logic          wp_n_pin,
  output logic          so,
  output logic          so_oe,
  output logic          hold_active,
  output logic          cmd_reset,
  output logic [DW-1:0] rx_byte,
  output logic          rx_valid,
  output logic [DW-1:0] status_reg,
  output logic          wrsr_done,
  output logic          wrsr_rejected
);
  localparam int CW = $clog2(DW);

  logic [4:0]    pins_s;
  logic          cs_n_s, sck_s, si_s, hold_n_s, wp_n_s;
  logic [CW-1:0] bit_cnt;

  pin_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b10011)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n_pin, sck_pin, si_pin, hold_n_pin, wp_n_pin}),
    .q   (pins_s)
  );

  assign {cs_n_s, sck_s, si_s, hold_n_s, wp_n_s} = pins_s;

  hold_qual u_hold (
    .clk         (clk),
    .rst         (rst),
    .cs_n_s      (cs_n_s),
    .sck_s       (sck_s),
    .hold_n_s    (hold_n_s),
    .hold_active (hold_active),
    .so_oe       (so_oe)
  );

  bit_shifter #(.DW(DW)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .cs_n_s      (cs_n_s),
    .sck_s       (sck_s),
    .si_s        (si_s),
    .hold_active (hold_active),
    .tx_load     (status_reg),
    .so          (so),
    .rx_byte     (rx_byte),
    .rx_valid    (rx_valid),
    .bit_cnt     (bit_cnt),
    .cmd_reset   (cmd_reset)
  );

  wrsr_gate #(.DW(DW)) u_gate (
    .clk           (clk),
    .rst           (rst),
    .cs_n_s        (cs_n_s),
    .wp_n_s        (wp_n_s),
    .rx_byte       (rx_byte),
    .rx_valid      (rx_valid),
    .status_reg    (status_reg),
    .wrsr_done     (wrsr_done),
    .wrsr_rejected (wrsr_rejected)
  );
endmodule

// File: rtl/spi_hold_chk.sv
module spi_hold_chk #(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n_s,
  input logic          sck_s,
  input logic          hold_n_s,
  input logic          wp_n_s,
  input logic          hold_active,
  input logic          so_oe,
  input logic          cmd_reset,
  input logic [CW-1:0] bit_cnt,
  input logic [DW-1:0] status_reg,
  input logic          wrsr_done,
  input logic          wrsr_rejected
);
  // R1
  hold_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_active) |-> $past(!cs_n_s));

  // R2
  hold_entry_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_active) |-> $past(!sck_s && !hold_n_s));

  // R4
  hold_exit_low_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(hold_active) && $past(!cs_n_s)) |-> $past(!sck_s && hold_n_s));

  // R5
  hold_drv_off_chk: assert property (@(posedge clk) disable iff (rst)
    hold_active |-> !so_oe);

  // R6
  hold_keeps_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_active && $past(hold_active)) |-> $stable(bit_cnt));

  // R7
  cs_clears_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !hold_active);

  // R7
  reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_reset |=> !cmd_reset);

  // R9
  refused_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    wrsr_rejected |-> ($stable(status_reg) && $past(status_reg[DW-1] && !wp_n_s)));

  // R12
  status_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(status_reg) |-> wrsr_done);
endmodule

bind spi_hold_frontend spi_hold_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cs_n_s        (cs_n_s),
  .sck_s         (sck_s),
  .hold_n_s      (hold_n_s),
  .wp_n_s        (wp_n_s),
  .hold_active   (hold_active),
  .so_oe         (so_oe),
  .cmd_reset     (cmd_reset),
  .bit_cnt       (bit_cnt),
  .status_reg    (status_reg),
  .wrsr_done     (wrsr_done),
  .wrsr_rejected (wrsr_rejected)
);

// File: tb/tb_spi_hold_frontend.sv
module tb_spi_hold_frontend;
  localparam int HP = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n_pin = 1'b1, sck_pin = 1'b0, si_pin = 1'b0, hold_n_pin = 1'b1, wp_n_pin = 1'b1;
  logic so, so_oe, hold_active, cmd_reset, rx_valid, wrsr_done, wrsr_rejected;
  logic [7:0] rx_byte, status_reg;

  int checks = 0, errors = 0;
  int n_done = 0, n_rej = 0, n_rst = 0, n_rx = 0;
  bit finished = 0;
  logic [7:0] st_model = 8'h00;

  always #10 clk = ~clk;

  spi_hold_frontend dut (
    .clk(clk), .rst(rst), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin), .si_pin(si_pin),
    .hold_n_pin(hold_n_pin), .wp_n_pin(wp_n_pin), .so(so), .so_oe(so_oe),
    .hold_active(hold_active), .cmd_reset(cmd_reset), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .status_reg(status_reg), .wrsr_done(wrsr_done),
    .wrsr_rejected(wrsr_rejected)
  );

  always @(negedge clk) if (!rst) begin
    n_done += int'(wrsr_done);
    n_rej  += int'(wrsr_rejected);
    n_rst  += int'(cmd_reset);
    n_rx   += int'(rx_valid);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] wrsr_model(input logic [7:0] st, input logic [7:0] op,
                                            input logic [7:0] d, input logic wp, output bit rej);
    rej = 0;
    if (op != 8'h01) return st;
    if (st[7] && !wp) begin rej = 1; return st; end
    return d;
  endfunction

  task automatic pause_body(input bit exit_hi);
    chk("R5 so_oe off in pause", so_oe, 0);
    repeat (3) begin
      si_pin = 1'($urandom); sck_pin = 1'b1; w(HP);
      sck_pin = 1'b0; w(HP);
    end
    chk("R5 pause held over sck activity", hold_active, 1);
    if (exit_hi) begin
      sck_pin = 1'b1; w(HP);
      hold_n_pin = 1'b1; w(HP);
      chk("R4 exit waits for sck low", hold_active, 1);
      sck_pin = 1'b0; w(5);
      chk("R4 exit at sck low", hold_active, 0);
    end else begin
      hold_n_pin = 1'b1; w(5);
      chk("R4 exit with sck low", hold_active, 0);
    end
    chk("R11 so_oe back on", so_oe, 1);
  endtask

  // hb: bit index for a pause (8 = none)
  task automatic xfer(input logic [7:0] tx, input int hb, input bit ent_hi, input bit exit_hi,
                      output logic [7:0] rd);
    for (int i = 0; i < 8; i++) begin
      if (i == hb && ent_hi) begin
        si_pin = tx[7-i]; w(HP);
        rd[7-i] = so; sck_pin = 1'b1; w(2);
        hold_n_pin = 1'b0; w(HP);
        chk("R3 entry waits for sck low", hold_active, 0);
        sck_pin = 1'b0; w(5);
        chk("R3 entry at sck low", hold_active, 1);
        pause_body(exit_hi);
      end else begin
        if (i == hb) begin
          w(HP);
          hold_n_pin = 1'b0; w(5);
          chk("R2 entry with sck low", hold_active, 1);
          pause_body(exit_hi);
        end
        si_pin = tx[7-i]; w(HP);
        rd[7-i] = so; sck_pin = 1'b1; w(HP);
        sck_pin = 1'b0;
      end
    end
  endtask

  task automatic txn(input logic [7:0] op, input logic [7:0] d, input logic wp, input int hb,
                     input bit ent_hi, input bit exit_hi);
    logic [7:0] r0, r1, exp_st, st0;
    bit rej;
    int rej0;
    rej0 = n_rej;
    st0 = st_model;
    wp_n_pin = wp;
    cs_n_pin = 1'b0; w(4);
    chk("R11 so_oe with cs low", so_oe, 1);
    xfer(op, 8, 0, 0, r0);
    chk("R10 opcode received", rx_byte, op);
    chk("R11 status shifted out", r0, st0);
    xfer(d, hb, ent_hi, exit_hi, r1);
    chk("R6 R10 data received after pause", rx_byte, d);
    w(HP);
    cs_n_pin = 1'b1; w(6);
    exp_st = wrsr_model(st0, op, d, wp, rej);
    st_model = exp_st;
    if (op == 8'h01) chk("R8 R9 status after write", status_reg, exp_st);
    else             chk("R12 status unchanged", status_reg, exp_st);
    chk("R9 rejected count", n_rej - rej0, int'(rej));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int rst0;
    void'($urandom(32'd1234));
    w(4); rst = 1'b0; w(4);
    chk("reset so_oe", so_oe, 0);
    chk("reset hold_active", hold_active, 0);
    chk("reset status", status_reg, 0);

    // R1: pause pin low with cs high
    hold_n_pin = 1'b0; w(8);
    chk("R1 no pause while cs high", hold_active, 0);
    hold_n_pin = 1'b1; w(4);

    // directed: write accepted, lock, refuse, wp override, unlock
    txn(8'h01, 8'h8C, 1'b1, 3, 0, 0);           // R8
    txn(8'h01, 8'h11, 1'b0, 8, 0, 0);           // R9 refused
    txn(8'h01, 8'h22, 1'b1, 5, 1, 1);           // R8 wp override, deferred pause edges
    txn(8'h01, 8'h33, 1'b0, 0, 1, 0);           // R8 lock clear
    txn(8'h9F, 8'h44, 1'b1, 7, 0, 1);           // R12

    // R7: cs released during a pause
    rst0 = n_rst;
    cs_n_pin = 1'b0; w(4);
    for (int i = 0; i < 3; i++) begin
      si_pin = 1'b1; w(HP); sck_pin = 1'b1; w(HP); sck_pin = 1'b0;
    end
    w(HP); hold_n_pin = 1'b0; w(5);
    chk("R7 pause before release", hold_active, 1);
    cs_n_pin = 1'b1; w(5);
    chk("R7 pause cleared by cs", hold_active, 0);
    chk("R7 cmd_reset pulse", n_rst - rst0, 1);
    hold_n_pin = 1'b1; w(4);
    cs_n_pin = 1'b0; w(4);
    xfer(8'hA5, 8, 0, 0, r);
    chk("R7 fresh bit position", rx_byte, 8'hA5);
    w(HP); cs_n_pin = 1'b1; w(6);

    // random transfers
    for (int k = 0; k < 40; k++) begin
      logic [7:0] op, d;
      op = ($urandom % 4 == 0) ? 8'($urandom) : 8'h01;
      d  = 8'($urandom);
      txn(op, d, 1'($urandom), ($urandom % 2) ? int'($urandom % 8) : 8,
          1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule